// File: doc/BRIEF.md
# Scaled Reference Time Calculator

The block turns a free-running virtual timestamp into a normalized reference time. It multiplies the timestamp by an unsigned 64-bit scale and keeps the upper 64 bits of the 128-bit product. It then adds a signed 64-bit offset. A writer may replace the scale and offset at any moment, so every computation reads them under a sequence-word consistency check. The sequence word is sampled once before the parameters are captured and once after. If the two samples differ, the capture is repeated.

A sequence value of zero marks the parameters as unusable. A control register also carries an enable bit. When the parameters are unusable or the enable bit is clear, the block answers with the value of a monotonic fallback counter. That counter counts 100 ns ticks and cannot be written.

The multiply runs over four cycles as 32x32 partial products. A busy flag shows that a request is in flight, and the block ignores requests while busy is high.

Top module: `refTimeCalc`

## Requirements
- R1: After reset, resultValid, busy, errFlag, result, seqRd, ctlRd and refCount are all zero.
- R2: With the enable bit set and a nonzero, stable sequence word, a request yields result = upper 64 bits of (tscIn x scale) + offset, where offset is two's complement and the sum is taken modulo 2^64. resultValid rises 8 cycles after the clock edge that accepted the request.
- R3: While bit 0 of the control register is clear, a request returns the fallback counter value sampled one edge after acceptance, with resultValid 2 cycles after acceptance.
- R4: With the enable bit set and the sequence word equal to zero at a sequence read, the request returns the fallback counter instead of a scaled value.
- R5: If the sequence word changes between the two sequence reads, the capture is repeated. The result then uses the new parameters and arrives 3 cycles later than in R2. If the repeated first read sees zero, the fallback value arrives 5 cycles after acceptance.
- R6: A parameter write without invalidate stores scale and offset and sets the sequence to its old value plus one, wrapping modulo 2^SEQ_W and skipping zero (the all-ones value goes to 1). A write with invalidate sets the sequence to zero.
- R7: busy is high from the edge after an accepted request until the cycle in which resultValid is high. A request presented while busy is ignored and produces no result.
- R8: The fallback counter starts at zero and increments by one on each edge where refTick is high. A write attempt (cntWrEn) leaves it unchanged and raises errFlag for exactly the following cycle.
- R9: The 64-bit control register reads back every written bit, including the reserved bits 11:1 and the page bits 63:12. Bit 0 is the enable.
- R10: resultValid is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tscIn | input | TIME_W | Free-running virtual timestamp |
| reqValid | input | 1 | Request a reference time (taken when not busy) |
| busy | output | 1 | A request is in flight |
| result | output | TIME_W | Computed reference time |
| resultValid | output | 1 | One-cycle strobe, result is valid |
| prmWrEn | input | 1 | Parameter update strobe |
| prmInvalidate | input | 1 | With prmWrEn: mark parameters unusable (sequence to zero) |
| prmScale | input | TIME_W | New unsigned scale |
| prmOffset | input | TIME_W | New signed offset |
| seqRd | output | SEQ_W | Current sequence word |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | TIME_W | Control register write data |
| ctlRd | output | TIME_W | Control register contents |
| refTick | input | 1 | One 100 ns tick of the fallback counter |
| cntWrEn | input | 1 | Write attempt on the fallback counter |
| refCount | output | TIME_W | Fallback counter value |
| errFlag | output | 1 | Write attempt on the fallback counter was rejected |

## Verification
Each result has a fixed due cycle counted from the edge that accepts the request: 8 edges for a scaled result, 2 for a fallback, 11 when an update lands during capture, and 5 when an invalidation lands there. The bench drives every input on the falling edge and counts falling edges until resultValid appears. It checks that count against the due cycle as well as the value. Parameter writes are timed to land exactly on the capture edge, so the retry paths are reached on purpose. Counter, sequence and control register effects are read back at the first falling edge after the write edge.

// File: rtl/rtcPkg.sv
package rtcPkg;

  typedef struct packed {
    logic capSeq;   // take first sequence sample
    logic capPrm;   // take timestamp, scale, offset; clear accumulator
    logic mulStep;  // accumulate one partial product
    logic sumDo;    // add offset, publish result
    logic fallDo;   // publish fallback counter
  } rtcStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEQ1,
    S_PRM,
    S_SEQ2,
    S_MUL,
    S_SUM,
    S_FALL
  } rtcState_t;

endpackage

// File: rtl/rtcParamRegs.sv
module rtcParamRegs #(
  parameter int TIME_W = 64,
  parameter int SEQ_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prmWrEn,
  input  logic              prmInvalidate,
  input  logic [TIME_W-1:0] prmScale,
  input  logic [TIME_W-1:0] prmOffset,
  input  logic              ctlWrEn,
  input  logic [TIME_W-1:0] ctlWrData,
  input  logic              refTick,
  input  logic              cntWrEn,
  output logic [TIME_W-1:0] scaleQ,
  output logic [TIME_W-1:0] offsetQ,
  output logic [SEQ_W-1:0]  seqQ,
  output logic [TIME_W-1:0] ctlQ,
  output logic [TIME_W-1:0] refCount,
  output logic              errFlag
);

  logic [SEQ_W-1:0] seqBump;

  // Next sequence value: increment with wrap, zero is reserved for invalidation
  always_comb begin
    seqBump = seqQ + SEQ_W'(1);
    if (seqBump == '0) seqBump = SEQ_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scaleQ  <= '0;
      offsetQ <= '0;
      seqQ    <= '0;
    end else if (prmWrEn) begin
      if (prmInvalidate) begin
        seqQ <= '0;
      end else begin
        scaleQ  <= prmScale;
        offsetQ <= prmOffset;
        seqQ    <= seqBump;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        ctlQ <= '0;
    else if (ctlWrEn) ctlQ <= ctlWrData;
  end

  // Fallback counter: tick-driven, write attempts are rejected and flagged
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCount <= '0;
      errFlag  <= 1'b0;
    end else begin
      errFlag <= cntWrEn;
      if (refTick) refCount <= refCount + TIME_W'(1);
    end
  end

endmodule

// File: rtl/rtcCtrl.sv
module rtcCtrl #(
  parameter int NUM_PP = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      enBit,
  input  logic                      seqZero,
  input  logic                      seqMatch,
  output rtcPkg::rtcStrobes_t       strb,
  output logic [$clog2(NUM_PP)-1:0] mulIdx,
  output logic                      busy
);
  import rtcPkg::*;

  localparam int CNT_W = $clog2(NUM_PP);

  rtcState_t  state, stateNext;
  logic [CNT_W-1:0] mulCnt;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (!enBit) begin
            stateNext = S_FALL;
          end else begin
            strb.capSeq = 1'b1;
            stateNext   = seqZero ? S_FALL : S_PRM;
          end
        end
      end
      S_SEQ1: begin
        strb.capSeq = 1'b1;
        stateNext   = seqZero ? S_FALL : S_PRM;
      end
      S_PRM: begin
        strb.capPrm = 1'b1;
        stateNext   = S_SEQ2;
      end
      S_SEQ2: stateNext = seqMatch ? S_MUL : S_SEQ1;
      S_MUL: begin
        strb.mulStep = 1'b1;
        if (mulCnt == CNT_W'(NUM_PP - 1)) stateNext = S_SUM;
      end
      S_SUM: begin
        strb.sumDo = 1'b1;
        stateNext  = S_IDLE;
      end
      S_FALL: begin
        strb.fallDo = 1'b1;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      mulCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == S_MUL) mulCnt <= mulCnt + CNT_W'(1);
      else                mulCnt <= '0;
    end
  end

  assign mulIdx = mulCnt;
  assign busy   = (state != S_IDLE);

endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath #(
  parameter int TIME_W = 64,
  parameter int SEQ_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  rtcPkg::rtcStrobes_t strb,
  input  logic [1:0]          mulIdx,
  input  logic [TIME_W-1:0]   tscIn,
  input  logic [TIME_W-1:0]   scaleQ,
  input  logic [TIME_W-1:0]   offsetQ,
  input  logic [SEQ_W-1:0]    seqQ,
  input  logic [TIME_W-1:0]   refCount,
  output logic                seqZero,
  output logic                seqMatch,
  output logic [TIME_W-1:0]   result,
  output logic                resultValid
);

  localparam int HALF_W = TIME_W / 2;
  localparam int PROD_W = 2 * TIME_W;

  logic [SEQ_W-1:0]  seq1Reg;
  logic [TIME_W-1:0] tscCap, scaleCap, offsetCap;
  logic [PROD_W-1:0] acc;
  logic [HALF_W-1:0] aPart, bPart;
  logic [TIME_W-1:0] pp;
  logic [PROD_W-1:0] ppExt, ppShift;

  assign seqZero  = (seqQ == '0);
  assign seqMatch = (seqQ == seq1Reg);

  // Partial product selection: bit 0 picks timestamp half, bit 1 picks scale half
  assign aPart = mulIdx[0] ? tscCap[TIME_W-1:HALF_W]   : tscCap[HALF_W-1:0];
  assign bPart = mulIdx[1] ? scaleCap[TIME_W-1:HALF_W] : scaleCap[HALF_W-1:0];
  assign pp    = {{HALF_W{1'b0}}, aPart} * {{HALF_W{1'b0}}, bPart};
  assign ppExt = {{TIME_W{1'b0}}, pp};

  always_comb begin
    unique case (mulIdx)
      2'd0:    ppShift = ppExt;
      2'd3:    ppShift = ppExt << TIME_W;
      default: ppShift = ppExt << HALF_W;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seq1Reg   <= '0;
      tscCap    <= '0;
      scaleCap  <= '0;
      offsetCap <= '0;
      acc       <= '0;
    end else begin
      if (strb.capSeq) seq1Reg <= seqQ;
      if (strb.capPrm) begin
        tscCap    <= tscIn;
        scaleCap  <= scaleQ;
        offsetCap <= offsetQ;
        acc       <= '0;
      end else if (strb.mulStep) begin
        acc <= acc + ppShift;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.sumDo | strb.fallDo;
      if (strb.sumDo)       result <= acc[PROD_W-1:TIME_W] + offsetCap;
      else if (strb.fallDo) result <= refCount;
    end
  end

endmodule

// File: rtl/refTimeCalc.sv
module refTimeCalc #(
  parameter int TIME_W = 64,
  parameter int SEQ_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] tscIn,
  input  logic              reqValid,
  output logic              busy,
  output logic [TIME_W-1:0] result,
  output logic              resultValid,
  input  logic              prmWrEn,
  input  logic              prmInvalidate,
  input  logic [TIME_W-1:0] prmScale,
  input  logic [TIME_W-1:0] prmOffset,
  output logic [SEQ_W-1:0]  seqRd,
  input  logic              ctlWrEn,
  input  logic [TIME_W-1:0] ctlWrData,
  output logic [TIME_W-1:0] ctlRd,
  input  logic              refTick,
  input  logic              cntWrEn,
  output logic [TIME_W-1:0] refCount,
  output logic              errFlag
);

  localparam int NUM_PP = 4;

  rtcPkg::rtcStrobes_t strb;
  logic [1:0]          mulIdx;
  logic [TIME_W-1:0]   scaleQ, offsetQ;
  logic                seqZero, seqMatch;

  rtcParamRegs #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_regs (
    .clk(clk), .rstN(rstN),
    .prmWrEn(prmWrEn), .prmInvalidate(prmInvalidate),
    .prmScale(prmScale), .prmOffset(prmOffset),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .refTick(refTick), .cntWrEn(cntWrEn),
    .scaleQ(scaleQ), .offsetQ(offsetQ), .seqQ(seqRd),
    .ctlQ(ctlRd), .refCount(refCount), .errFlag(errFlag)
  );

  rtcCtrl #(.NUM_PP(NUM_PP)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .enBit(ctlRd[0]),
    .seqZero(seqZero), .seqMatch(seqMatch),
    .strb(strb), .mulIdx(mulIdx), .busy(busy)
  );

  rtcDatapath #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mulIdx(mulIdx),
    .tscIn(tscIn), .scaleQ(scaleQ), .offsetQ(offsetQ), .seqQ(seqRd),
    .refCount(refCount), .seqZero(seqZero), .seqMatch(seqMatch),
    .result(result), .resultValid(resultValid)
  );

endmodule

// File: rtl/rtcChecker.sv
module rtcChecker #(
  parameter int TIME_W = 64,
  parameter int SEQ_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              resultValid,
  input logic              prmWrEn,
  input logic              prmInvalidate,
  input logic [SEQ_W-1:0]  seqRd,
  input logic              ctlWrEn,
  input logic [TIME_W-1:0] ctlWrData,
  input logic [TIME_W-1:0] ctlRd,
  input logic              refTick,
  input logic              cntWrEn,
  input logic [TIME_W-1:0] refCount,
  input logic              errFlag
);

  // R7
  req_takes_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  // R10
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(busy));

  // R10
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R6
  seq_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prmWrEn && !prmInvalidate) |=> (seqRd != '0));

  // R6
  seq_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prmWrEn && prmInvalidate) |=> (seqRd == '0));

  // R8
  cnt_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    refTick |=> (refCount == $past(refCount) + TIME_W'(1)));

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refTick |=> $stable(refCount));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> errFlag);

  // R9
  ctl_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> (ctlRd == $past(ctlWrData)));

endmodule

bind refTimeCalc rtcChecker #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) i_rtcChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy),
  .resultValid(resultValid), .prmWrEn(prmWrEn), .prmInvalidate(prmInvalidate),
  .seqRd(seqRd), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlRd(ctlRd),
  .refTick(refTick), .cntWrEn(cntWrEn), .refCount(refCount), .errFlag(errFlag)
);

// File: tb/test_refTimeCalc.sv
module test_refTimeCalc;

  localparam int TW = 64;
  localparam int SW = 4;
  localparam int NV = 5;

  // {tsc, scale, offset}
  localparam logic [3*TW-1:0] VEC [NV] = '{
    {64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0000},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0010},
    {64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
    {64'hDEAD_BEEF_0000_0001, 64'h0000_0000_0000_0000, 64'h7FFF_0000_0000_0000},
    {64'h0000_0000_1234_5678, 64'h0000_1000_0000_0000, 64'hFFFF_FFFF_FFFF_F000}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] tscIn = '0;
  logic          reqValid = 1'b0;
  logic          busy;
  logic [TW-1:0] result;
  logic          resultValid;
  logic          prmWrEn = 1'b0;
  logic          prmInvalidate = 1'b0;
  logic [TW-1:0] prmScale = '0;
  logic [TW-1:0] prmOffset = '0;
  logic [SW-1:0] seqRd;
  logic          ctlWrEn = 1'b0;
  logic [TW-1:0] ctlWrData = '0;
  logic [TW-1:0] ctlRd;
  logic          refTick = 1'b0;
  logic          cntWrEn = 1'b0;
  logic [TW-1:0] refCount;
  logic          errFlag;

  int total = 0;
  int bad = 0;
  logic [SW-1:0] seqModel = '0;
  logic [TW-1:0] cntModel = '0;
  logic [TW-1:0] gotRes;
  int gotLat;

  always #4 clk = ~clk;

  refTimeCalc #(.TIME_W(TW), .SEQ_W(SW)) i_refTimeCalc (
    .clk(clk), .rstN(rstN), .tscIn(tscIn), .reqValid(reqValid), .busy(busy),
    .result(result), .resultValid(resultValid), .prmWrEn(prmWrEn),
    .prmInvalidate(prmInvalidate), .prmScale(prmScale), .prmOffset(prmOffset),
    .seqRd(seqRd), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlRd(ctlRd),
    .refTick(refTick), .cntWrEn(cntWrEn), .refCount(refCount), .errFlag(errFlag)
  );

  function automatic logic [TW-1:0] refCalc(logic [TW-1:0] t, logic [TW-1:0] s,
                                            logic [TW-1:0] o);
    logic [2*TW-1:0] p;
    p = {{TW{1'b0}}, t} * {{TW{1'b0}}, s};
    return p[2*TW-1:TW] + o;
  endfunction

  task automatic chk(bit ok, string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic prmWrite(logic [TW-1:0] s, logic [TW-1:0] o, bit inval);
    @(negedge clk);
    prmWrEn = 1'b1; prmInvalidate = inval; prmScale = s; prmOffset = o;
    @(negedge clk);
    prmWrEn = 1'b0; prmInvalidate = 1'b0;
    if (inval) seqModel = '0;
    else begin
      seqModel = seqModel + SW'(1);
      if (seqModel == '0) seqModel = SW'(1);
    end
  endtask

  task automatic ctlWrite(logic [TW-1:0] d);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  // mode 0: quiet; 1: update lands on capture edge; 2: invalidate lands there
  task automatic doReq(int mode, logic [TW-1:0] s, logic [TW-1:0] o);
    @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    gotLat = 1;
    if (mode != 0) begin
      prmWrEn = 1'b1; prmInvalidate = (mode == 2); prmScale = s; prmOffset = o;
    end
    if (resultValid) gotRes = result;
    while (!resultValid && gotLat < 40) begin
      @(negedge clk);
      if (mode != 0 && gotLat == 1) begin
        prmWrEn = 1'b0; prmInvalidate = 1'b0;
        if (mode == 2) seqModel = '0;
        else begin
          seqModel = seqModel + SW'(1);
          if (seqModel == '0) seqModel = SW'(1);
        end
      end
      gotLat++;
    end
    gotRes = result;
    @(negedge clk);
    chk(!resultValid, "R10 valid pulse width", TW'(resultValid), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!resultValid && !busy && !errFlag, "R1 flags", {61'b0, resultValid, busy, errFlag}, '0);
    chk(result == '0 && refCount == '0, "R1 result/count", result | refCount, '0);
    chk(ctlRd == '0 && seqRd == '0, "R1 ctl/seq", ctlRd | TW'(seqRd), '0);

    // R8 ticks, then a rejected write
    for (int i = 0; i < 5; i++) begin
      refTick = 1'b1; @(negedge clk); cntModel++;
    end
    refTick = 1'b0;
    chk(refCount == cntModel, "R8 tick count", refCount, cntModel);
    cntWrEn = 1'b1;
    @(negedge clk);
    cntWrEn = 1'b0;
    chk(errFlag == 1'b1, "R8 error raised", TW'(errFlag), 1);
    chk(refCount == cntModel, "R8 write ignored", refCount, cntModel);
    @(negedge clk);
    chk(errFlag == 1'b0, "R8 error one cycle", TW'(errFlag), 0);

    // R3 disabled: fallback
    doReq(0, '0, '0);
    chk(gotRes == cntModel, "R3 fallback value", gotRes, cntModel);
    chk(gotLat == 2, "R3 fallback latency", TW'(gotLat), 2);

    // R9 reserved and page bits kept, enable still clear
    ctlWrite(64'hABCD_E000_0000_0FFE);
    chk(ctlRd == 64'hABCD_E000_0000_0FFE, "R9 readback", ctlRd, 64'hABCD_E000_0000_0FFE);
    prmWrite(64'h1, 64'h1, 1'b0);
    chk(TW'(seqRd) == TW'(seqModel), "R6 first bump", TW'(seqRd), TW'(seqModel));
    doReq(0, '0, '0);
    chk(gotRes == cntModel, "R3 disabled with params", gotRes, cntModel);
    ctlWrite(64'h0000_1234_5000_0A55);
    chk(ctlRd == 64'h0000_1234_5000_0A55, "R9 readback enable", ctlRd, 64'h0000_1234_5000_0A55);

    // R4 sequence zero
    prmWrite('0, '0, 1'b1);
    chk(seqRd == '0, "R6 invalidate", TW'(seqRd), '0);
    doReq(0, '0, '0);
    chk(gotRes == cntModel && gotLat == 2, "R4 zero sequence fallback", gotRes, cntModel);

    // R2 vector table
    for (int v = 0; v < NV; v++) begin
      logic [TW-1:0] t, s, o, e;
      {t, s, o} = VEC[v];
      prmWrite(s, o, 1'b0);
      chk(TW'(seqRd) == TW'(seqModel), "R6 bump", TW'(seqRd), TW'(seqModel));
      tscIn = t;
      e = refCalc(t, s, o);
      doReq(0, '0, '0);
      chk(gotRes == e, "R2 scaled value", gotRes, e);
      chk(gotLat == 8, "R2 latency", TW'(gotLat), 8);
    end

    // R5 update lands during capture: retry with new parameters
    tscIn = 64'h0000_0003_0000_0000;
    doReq(1, 64'h0000_0002_0000_0000, 64'h0000_0000_0000_0100);
    chk(gotRes == refCalc(tscIn, 64'h0000_0002_0000_0000, 64'h100), "R5 retry value",
        gotRes, refCalc(tscIn, 64'h0000_0002_0000_0000, 64'h100));
    chk(gotLat == 11, "R5 retry latency", TW'(gotLat), 11);

    // R5 invalidation lands during capture: retry ends in fallback
    doReq(2, '0, '0);
    chk(gotRes == cntModel, "R5 retry fallback value", gotRes, cntModel);
    chk(gotLat == 5, "R5 retry fallback latency", TW'(gotLat), 5);

    // R7 busy and ignored request
    prmWrite(64'h0000_0001_0000_0000, 64'h5, 1'b0);
    tscIn = 64'h77;
    @(negedge clk); reqValid = 1'b1;
    @(negedge clk); reqValid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", TW'(busy), 1);
    @(negedge clk); reqValid = 1'b1;
    @(negedge clk); reqValid = 1'b0;
    begin
      int nv = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (resultValid) nv++;
      end
      chk(nv == 1, "R7 request while busy ignored", TW'(nv), 1);
      chk(!busy, "R7 idle after result", TW'(busy), 0);
    end

    // R6 wrap skips zero
    for (int k = 0; k < 18; k++) begin
      prmWrite(64'h1, 64'h0, 1'b0);
      chk(TW'(seqRd) == TW'(seqModel) && seqRd != '0, "R6 wrap", TW'(seqRd), TW'(seqModel));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule